// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus on which a target device has stopped partway through a byte and is holding SDA low. A recovery request, or a timeout pulse from a transaction watchdog, starts a sequence. The block takes the SCL and SDA open-drain drivers away from the normal I2C master and clocks SCL until the target lets go of SDA. It then forms a STOP condition, hands the pins back, and pulses a soft reset into the master core. That reset clears the core's internal state and its bus-busy indication, which a plain re-initialisation of the core would leave set.

Each SCL half period is a programmable number of system clocks. The value is captured when the sequence starts. High phases are timed only from the moment the SCL readback is high, so a target that stretches the clock lengthens the phase. The block gives up after a fixed number of pulses. It still finishes the STOP and the soft reset in that case, and reports fail rather than success.

In this block a pin output of 1 means "pull the line low". A 0 output releases the line and lets the pull-up take it high.

Top module: `i2c_bus_unstick`

## Requirements
- R1: From the cycle after a request is accepted until the STOP sequence ends, `own_sel` is 1. `scl_oe` and `sda_oe` are only ever 1 while `own_sel` is 1. `own_sel` is only 1 while `busy` is 1.
- R2: A sequence produces at least 1 and at most MAX_PULSES (default 9) SCL pulses. A pulse is counted each time `scl_oe` rises while `sda_oe` is 0. Each such low drive lasts exactly D system clocks.
- R3: SDA is sampled at the last cycle of each SCL high phase. If it reads 1, no further pulse follows. A target that releases SDA during pulse K therefore yields max(K,1) pulses.
- R4: The STOP sequence drives SDA low while SCL is driven low, then releases SCL, then releases SDA. `sda_oe` falls exactly once per sequence, and at that moment the SCL line is high.
- R5: Each high phase lasts exactly D cycles, counted from the cycle the SCL readback is high. A target holding SCL low lengthens the phase but not the count.
- R6: After `own_sel` returns to 0, `core_srst` is 1 for exactly SRST_CYCLES (default 4) consecutive cycles, once per sequence, with both pin outputs at 0.
- R7: D equals `half_div` as captured when the request is accepted, with values below 2 taken as 2. Later changes to `half_div` have no effect on the running sequence.
- R8: At the end of a sequence, `done_ok` is set if SDA was seen released, otherwise `done_fail` is set. Both are never 1 together.
- R9: A request arriving while `busy` is 1 is ignored; the running sequence keeps its pulse count and timing. `done_ok`/`done_fail` hold until the next accepted request, which clears them while `busy` is 1.
- R10: A 1 on `wdog_timeout` while idle starts a sequence exactly as `start_req` does. `busy` and `own_sel` are 1 on the next cycle.
- R11: Asynchronous reset makes every output 0: lines released, master owns the pins, status cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Recovery request, sampled while idle |
| wdog_timeout | input | 1 | Watchdog timeout, starts recovery like a request |
| half_div | input | DIV_W | SCL half period in system clocks (min 2) |
| scl_in | input | 1 | SCL line readback |
| sda_in | input | 1 | SDA line readback |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_sel | output | 1 | 1 = this block owns the pins, 0 = normal master |
| core_srst | output | 1 | Soft-reset pulse to the master core |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Last sequence freed SDA |
| done_fail | output | 1 | Last sequence ended with SDA still low |

## Verification
The hardest situation to reach from the ports is a target that lets go of SDA exactly on the ninth pulse, or one that stretches SCL. Either case needs the bus itself to react to the block's own drive. The bench therefore models the target: it counts the SCL releases the block makes and frees SDA after a chosen number of them. It can also hold SCL low for a chosen number of cycles after every release. Sweeping the release point across 0, mid-range, exactly the limit and beyond the limit exercises both the early exit and the fail path. The stretch setting shows that the measured high phase still equals the divider.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LO,
    ST_STOP_SCL,
    ST_STOP_SDA,
    ST_SRST
  } unstick_state_e;
endpackage

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/unstick_pulse_count.sv
module unstick_pulse_count #(
  parameter int LIMIT = 9,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && !at_limit)   count <= count + CW'(1);
  end

  assign at_limit = (count == CW'(LIMIT));
endmodule

// File: rtl/unstick_pin_decode.sv
module unstick_pin_decode
  import unstick_pkg::*;
(
  input  unstick_state_e state,
  output logic           scl_pull,
  output logic           sda_pull,
  output logic           own,
  output logic           srst,
  output logic           active
);
  always_comb begin
    scl_pull = (state == ST_LOW) || (state == ST_STOP_LO);
    sda_pull = (state == ST_STOP_LO) || (state == ST_STOP_SCL);
    own      = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_STOP_LO)
            || (state == ST_STOP_SCL) || (state == ST_STOP_SDA);
    srst     = (state == ST_SRST);
    active   = (state != ST_IDLE);
  end
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import unstick_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MAX_PULSES  = 9,
  parameter int SRST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             wdog_timeout,
  input  logic [DIV_W-1:0] half_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             own_sel,
  output logic             core_srst,
  output logic             busy,
  output logic             done_ok,
  output logic             done_fail
);
  localparam int CNT_W = $clog2(MAX_PULSES + 1);

  // Divider floor: half periods shorter than two clocks are stretched to two.
  function automatic logic [DIV_W-1:0] floor_div(input logic [DIV_W-1:0] v);
    return (v < DIV_W'(2)) ? DIV_W'(2) : v;
  endfunction

  unstick_state_e   state_q, state_d;
  logic [DIV_W-1:0] div_q;
  logic             fail_pend_q;

  // Named internal events
  logic             req_take;
  logic             phase_end;
  logic             sda_free_seen;
  logic             limit_hit;
  logic             tmr_run;
  logic             tmr_expired;
  logic             tmr_load;
  logic [DIV_W-1:0] tmr_val;
  logic [CNT_W-1:0] pulse_cnt;
  logic             pulse_at_max;

  assign req_take  = (state_q == ST_IDLE) && (start_req || wdog_timeout);
  // High phases only count while the line is really high (clock stretch).
  assign tmr_run   = ((state_q == ST_HIGH) || (state_q == ST_STOP_SCL)) ? scl_in : 1'b1;
  assign phase_end = (state_q != ST_IDLE) && tmr_run && tmr_expired;
  assign sda_free_seen = (state_q == ST_HIGH) && phase_end && sda_in;
  assign limit_hit     = (state_q == ST_HIGH) && phase_end && !sda_in && pulse_at_max;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_take) state_d = ST_LOW;
      ST_LOW:      if (phase_end) state_d = ST_HIGH;
      ST_HIGH:     if (phase_end) state_d = (sda_free_seen || limit_hit) ? ST_STOP_LO : ST_LOW;
      ST_STOP_LO:  if (phase_end) state_d = ST_STOP_SCL;
      ST_STOP_SCL: if (phase_end) state_d = ST_STOP_SDA;
      ST_STOP_SDA: if (phase_end) state_d = ST_SRST;
      ST_SRST:     if (phase_end) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = req_take || phase_end;
  always_comb begin
    if (req_take)                 tmr_val = floor_div(half_div) - DIV_W'(1);
    else if (state_d == ST_SRST)  tmr_val = DIV_W'(SRST_CYCLES - 1);
    else                          tmr_val = div_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      div_q       <= DIV_W'(2);
      fail_pend_q <= 1'b0;
      done_ok     <= 1'b0;
      done_fail   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_take) begin
        div_q       <= floor_div(half_div);
        fail_pend_q <= 1'b0;
        done_ok     <= 1'b0;
        done_fail   <= 1'b0;
      end else begin
        if (limit_hit) fail_pend_q <= 1'b1;
        if ((state_q == ST_SRST) && phase_end) begin
          done_ok   <= !fail_pend_q;
          done_fail <= fail_pend_q;
        end
      end
    end
  end

  unstick_phase_timer #(.W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (tmr_expired)
  );

  unstick_pulse_count #(.LIMIT(MAX_PULSES), .CW(CNT_W)) u_pulses (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (req_take),
    .inc      ((state_q == ST_LOW) && phase_end),
    .count    (pulse_cnt),
    .at_limit (pulse_at_max)
  );

  unstick_pin_decode u_pins (
    .state    (state_q),
    .scl_pull (scl_oe),
    .sda_pull (sda_oe),
    .own      (own_sel),
    .srst     (core_srst),
    .active   (busy)
  );
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
  parameter int CNT_W       = 4,
  parameter int DIV_W       = 8,
  parameter int MAX_PULSES  = 9,
  parameter int SRST_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             wdog_timeout,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             own_sel,
  input logic             core_srst,
  input logic             busy,
  input logic             done_ok,
  input logic             done_fail,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic [DIV_W-1:0] div_q
);
  logic [7:0] srst_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       srst_run <= '0;
    else if (!core_srst)              srst_run <= '0;
    else if (srst_run != 8'hFF)       srst_run <= srst_run + 8'd1;
  end

  assert_pins_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe || sda_oe) |-> own_sel);
  assert_own_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    own_sel |-> busy);
  assert_pulse_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(MAX_PULSES));
  assert_stop_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_oe);
  assert_srst_pins_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst |-> (!own_sel && !scl_oe && !sda_oe));
  assert_srst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_srst) |-> (srst_run == 8'(SRST_CYCLES)));
  assert_div_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));
  assert_div_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_q >= DIV_W'(2)));
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fail));
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done_ok && !done_fail));
  assert_req_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start_req || wdog_timeout)) |=> (busy && own_sel));
endmodule

bind i2c_bus_unstick unstick_checker #(
  .CNT_W(CNT_W), .DIV_W(DIV_W), .MAX_PULSES(MAX_PULSES), .SRST_CYCLES(SRST_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_req    (start_req),
  .wdog_timeout (wdog_timeout),
  .scl_oe       (scl_oe),
  .sda_oe       (sda_oe),
  .own_sel      (own_sel),
  .core_srst    (core_srst),
  .busy         (busy),
  .done_ok      (done_ok),
  .done_fail    (done_fail),
  .pulse_cnt    (pulse_cnt),
  .div_q        (div_q)
);

// File: tb/sim_i2c_bus_unstick.sv
module sim_i2c_bus_unstick;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 9;
  localparam int SRST_LEN   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic       wdog_timeout = 1'b0;
  logic [7:0] half_div = 8'd4;
  logic       scl_oe, sda_oe, own_sel, core_srst, busy, done_ok, done_fail;
  logic       scl_line, sda_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus model: target holds SDA until it has seen tgt_k SCL releases,
  // and may stretch every SCL release by stretch_len cycles.
  int   tgt_k = 0;
  int   stretch_len = 0;
  int   rel_seen = 0;
  int   stretch_cnt = 0;
  logic prev_oe_model = 1'b0;

  assign scl_line = !(scl_oe || (stretch_cnt > 0));
  assign sda_line = !(sda_oe || (rel_seen < tgt_k));

  i2c_bus_unstick u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .wdog_timeout(wdog_timeout),
    .half_div(half_div), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_sel(own_sel), .core_srst(core_srst),
    .busy(busy), .done_ok(done_ok), .done_fail(done_fail)
  );

  always @(negedge clk) begin
    if (!busy) rel_seen <= 0;
    else if (prev_oe_model && !scl_oe && !sda_oe) rel_seen <= rel_seen + 1;
    if (prev_oe_model && !scl_oe) stretch_cnt <= stretch_len;
    else if (stretch_cnt > 0) stretch_cnt <= stretch_cnt - 1;
    prev_oe_model <= scl_oe;
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct { int pulses; bit fail; int d; } exp_t;
  exp_t sb_q[$];
  int   runs_seen = 0;

  // Monitor: 1 time unit after the falling edge, after the bus model settles
  int m_pulses, m_stops, m_srst_len, m_srst_cnt, m_bad_low, m_bad_high, m_srst_own;
  int lrun, hrun;
  bit in_low, in_high;
  logic m_busy = 0, m_scl_oe = 0, m_sda_oe = 0, m_scl_line = 1, m_srst = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (busy && !m_busy) begin
        m_pulses = 0; m_stops = 0; m_srst_len = 0; m_srst_cnt = 0;
        m_bad_low = 0; m_bad_high = 0; m_srst_own = 0; in_low = 0; in_high = 0;
        check(!done_ok && !done_fail, "R9 flags cleared at start", int'({done_ok, done_fail}), 0);
      end
      if (busy) begin
        int d;
        d = (sb_q.size() > 0) ? sb_q[0].d : 0;
        if (scl_oe && !m_scl_oe && !sda_oe) begin m_pulses++; in_low = 1; lrun = 1; end
        else if (in_low && scl_oe) lrun++;
        else if (in_low && !scl_oe) begin in_low = 0; if (lrun != d) m_bad_low++; end
        if (scl_line && !m_scl_line && own_sel && !sda_oe) begin in_high = 1; hrun = 1; end
        else if (in_high && scl_line) hrun++;
        else if (in_high && !scl_line) begin in_high = 0; if (hrun != d) m_bad_high++; end
        if (!sda_oe && m_sda_oe && scl_line) m_stops++;
        if (core_srst) begin m_srst_len++; if (own_sel || scl_oe || sda_oe) m_srst_own++; end
        if (core_srst && !m_srst) m_srst_cnt++;
        if ((scl_oe || sda_oe) && !own_sel) check(0, "R1 pin driven without ownership", 1, 0);
      end
      if (!busy && m_busy) begin
        exp_t e;
        runs_seen++;
        if (sb_q.size() == 0) check(0, "R9 unexpected sequence", runs_seen, 0);
        else begin
          e = sb_q.pop_front();
          check(m_pulses == e.pulses, "R2/R3 pulse count", m_pulses, e.pulses);
          check(m_bad_low == 0, "R2 low phase length", m_bad_low, 0);
          check(m_bad_high == 0, "R5 high phase length", m_bad_high, 0);
          check(m_stops == 1, "R4 STOP edge with SCL high", m_stops, 1);
          check(m_srst_len == SRST_LEN && m_srst_cnt == 1, "R6 soft reset pulse", m_srst_len, SRST_LEN);
          check(m_srst_own == 0, "R6 pins free during soft reset", m_srst_own, 0);
          check(done_ok == !e.fail && done_fail == e.fail, "R8 result flags",
                int'({done_ok, done_fail}), int'({!e.fail, e.fail}));
        end
      end
      m_busy = busy; m_scl_oe = scl_oe; m_sda_oe = sda_oe; m_scl_line = scl_line; m_srst = core_srst;
    end
  end

  function automatic int exp_pulses(input int k);
    return (k < 1) ? 1 : ((k > LIMIT) ? LIMIT : k);
  endfunction

  task automatic run_case(input int k, input int d, input int s, input bit use_wd, input bit poke);
    exp_t e;
    @(negedge clk);
    tgt_k = k; stretch_len = s; half_div = 8'(d);
    e.pulses = exp_pulses(k); e.fail = (k > LIMIT); e.d = (d < 2) ? 2 : d;
    sb_q.push_back(e);
    if (use_wd) wdog_timeout = 1'b1; else start_req = 1'b1;
    @(negedge clk);
    wdog_timeout = 1'b0; start_req = 1'b0;
    check(busy && own_sel, use_wd ? "R10 watchdog start" : "R1 ownership taken", int'(busy), 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      start_req = 1'b1; half_div = 8'(d + 5);
      @(negedge clk);
      start_req = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (15) @(negedge clk);
    check(!busy && !own_sel, "R9 no restart from ignored request", int'(busy), 0);
    check(done_ok == !e.fail && done_fail == e.fail, "R9 flags held",
          int'({done_ok, done_fail}), int'({!e.fail, e.fail}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, own_sel, core_srst, busy, done_ok, done_fail} == 7'b0,
          "R11 reset outputs", int'({scl_oe, sda_oe, own_sel, core_srst, busy, done_ok, done_fail}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(3, 4, 0, 0, 0);   // R3 early release mid-range
    run_case(0, 2, 0, 0, 0);   // R3 already released: single pulse
    run_case(9, 3, 0, 0, 0);   // R3 release on the final pulse
    run_case(12, 2, 0, 0, 0);  // R8 never released: fail after limit
    run_case(5, 0, 0, 0, 0);   // R7 divider below floor
    run_case(4, 5, 3, 0, 0);   // R5 clock stretch
    run_case(2, 3, 0, 1, 0);   // R10 watchdog start
    run_case(6, 3, 0, 0, 1);   // R9 request and divider change mid-run (R7)
    check(sb_q.size() == 0 && runs_seen == 8, "R9 one sequence per request", runs_seen, 8);
    rst_n = 1'b0;
    @(negedge clk);
    check({scl_oe, sda_oe, own_sel, busy, done_ok, done_fail} == 6'b0,
          "R11 reset clears status", int'({done_ok, done_fail}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule